// File: doc/BRIEF.md
# ECC Page Error Report Aggregator

This block sits behind a BCH decoder in a NAND flash read path. The decoder hands over one result per packet of a page: a decode-ok flag and a 6-bit corrected-bit count. The aggregator turns the results for one page into a single 32-bit status word. The first packet of the page gets a byte of its own. All later packets are merged into a second byte that holds their worst case: the ok flags are ANDed together and the largest count is kept. A page-empty indication, which comes from the transfer engine, is folded into the word as well. From these the block derives a page-level result: a corrected-bitflip count, or a flag saying the page cannot be corrected.

A `page_start` pulse opens a page. After that, each cycle with `pkt_valid` high delivers one packet result. When the `NUM_PKTS`-th packet has been taken, the block raises `page_done` for one cycle. The report word and the page result then hold steady until the next `page_start`.

A small state machine steers the sequence. It has four states:
- `ST_IDLE`: waiting, with no page open.
- `ST_FIRST`: waiting for packet 0.
- `ST_REST`: waiting for packets 1 to N-1.
- `ST_DONE`: the one-cycle completion state.

Its transitions are:
- Any state goes to `ST_FIRST` on `page_start`.
- `ST_FIRST` goes to `ST_REST` when packet 0 is taken, or straight to `ST_DONE` when a page holds a single packet.
- `ST_REST` goes to `ST_DONE` when the last packet is taken.
- `ST_DONE` goes to `ST_IDLE` on the next cycle.

Top module: `ecc_page_report`

## Requirements
- R1: The first packet taken after `page_start` sets report bit 7 to its ok flag and report bits 5..0 to its error count.
- R2: Report bit 15 is the AND of the ok flags of packets 1..N-1 of the page. Report bits 13..8 hold the largest error count among those packets, and that field never decreases within a page.
- R3: `page_start` clears the packet index and resets both ok flags to 1, both counts to 0 and the empty bit to 0, so the report reads 0x00008080. This holds in every state, including in the middle of a page. When `page_start` and `pkt_valid` are high together, the packet is dropped.
- R4: `page_done` is high for exactly one cycle: the cycle after the `NUM_PKTS`-th packet of the page is taken. From that cycle until the next `page_start`, the report word does not change.
- R5: When report bits 7 and 15 are both 1 and the page is not empty, `page_bitflips` equals the larger of the two count fields and `page_fail` is 0. When either bit is 0 and the page is not empty, `page_fail` is 1 and `page_bitflips` is 0.
- R6: `page_blank` is sampled only with the last packet of the page and is shown in report bit 16. When that bit is 1, `page_bitflips` is 0 and `page_fail` is 0, whatever the count fields hold.
- R7: Report bits 6, 14 and 31..17 are always 0.
- R8: `pkt_valid` has no effect while no page is open (`ST_IDLE` or `ST_DONE`). The report stays unchanged and `page_done` stays low.
- R9: After reset, the report reads 0x00008080, `page_done` is 0, `page_fail` is 0 and `page_bitflips` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| page_start | input | 1 | One-cycle pulse that opens a new page |
| pkt_valid | input | 1 | A packet result is present this cycle |
| pkt_ok | input | 1 | The packet decoded successfully |
| pkt_errs | input | 6 | Corrected bit count of the packet |
| page_blank | input | 1 | Page-empty indication, sampled with the last packet |
| report_word | output | 32 | Aggregated page status word |
| page_done | output | 1 | One-cycle pulse when the page report is complete |
| page_bitflips | output | 6 | Page-level corrected bitflip count |
| page_fail | output | 1 | The page is uncorrectable |

## Verification
The bench builds the block with `NUM_PKTS = 4`. This gives pages with one packet 0 and three merged packets, so the worst-case fold, the sticky failure AND and the last-packet detection can all be reached within a few cycles each. Back-to-back packets, gaps between packets, restarts in the middle of a page, a start that collides with a valid packet, and stray packets while idle are all driven. The bench's behavioural model is compared with every output field on every cycle.

// File: rtl/ecc_rpt_pkg.sv
package ecc_rpt_pkg;
    localparam int CNT_W     = 6;
    localparam int REPORT_W  = 32;
    localparam int CNT0_LSB  = 0;
    localparam int OK0_BIT   = 7;
    localparam int CNTN_LSB  = 8;
    localparam int OKN_BIT   = 15;
    localparam int EMPTY_BIT = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRST = 2'd1,
        ST_REST  = 2'd2,
        ST_DONE  = 2'd3
    } rpt_state_e;
endpackage

// File: rtl/ecc_rpt_seq.sv
module ecc_rpt_seq
    import ecc_rpt_pkg::*;
#(
    parameter int NUM_PKTS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic page_start,
    input  logic pkt_valid,
    output logic take_first,
    output logic take_rest,
    output logic take_last,
    output logic page_done
);
    localparam int IDX_W = (NUM_PKTS > 1) ? $clog2(NUM_PKTS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PKTS - 1);

    rpt_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q;

    // Packet acceptance strobes; a start always takes precedence.
    always_comb begin
        take_first = (state_q == ST_FIRST) && pkt_valid && !page_start;
        take_rest  = (state_q == ST_REST)  && pkt_valid && !page_start;
    end

    generate
        if (NUM_PKTS == 1) begin : g_single
            assign take_last = take_first;
        end else begin : g_multi
            assign take_last = take_rest && (idx_q == LAST_IDX);
        end
    endgenerate

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (page_start) begin
            state_d = ST_FIRST;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_FIRST: if (take_first) state_d = take_last ? ST_DONE : ST_REST;
                ST_REST:  if (take_last)  state_d = ST_DONE;
                ST_DONE:  state_d = ST_IDLE;
            endcase
        end
    end

    // State register and packet index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (page_start)
                idx_q <= '0;
            else if (take_first || take_rest)
                idx_q <= idx_q + IDX_W'(1);
        end
    end

    // Outputs
    always_comb begin
        page_done = (state_q == ST_DONE);
    end

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        page_done |=> !page_done);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !page_start) |=> (state_q == ST_IDLE));

    // R3
    start_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        page_start |=> (state_q == ST_FIRST && idx_q == '0));
endmodule

// File: rtl/ecc_rpt_fold.sv
module ecc_rpt_fold
    import ecc_rpt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             page_start,
    input  logic             take_first,
    input  logic             take_rest,
    input  logic             take_last,
    input  logic             pkt_ok,
    input  logic [CNT_W-1:0] pkt_errs,
    input  logic             page_blank,
    output logic             ok0_q,
    output logic [CNT_W-1:0] cnt0_q,
    output logic             okn_q,
    output logic [CNT_W-1:0] cntn_q,
    output logic             blank_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ok0_q   <= 1'b1;
            cnt0_q  <= '0;
            okn_q   <= 1'b1;
            cntn_q  <= '0;
            blank_q <= 1'b0;
        end else if (page_start) begin
            ok0_q   <= 1'b1;
            cnt0_q  <= '0;
            okn_q   <= 1'b1;
            cntn_q  <= '0;
            blank_q <= 1'b0;
        end else begin
            if (take_first) begin
                ok0_q  <= pkt_ok;
                cnt0_q <= pkt_errs;
            end
            if (take_rest) begin
                okn_q <= okn_q & pkt_ok;
                if (pkt_errs > cntn_q)
                    cntn_q <= pkt_errs;
            end
            if (take_last)
                blank_q <= page_blank;
        end
    end

    // R2
    okn_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!page_start && !okn_q) |=> !okn_q);

    // R2
    cntn_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !page_start |=> (cntn_q >= $past(cntn_q)));

    // R3
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        page_start |=> (okn_q && ok0_q && cntn_q == '0 && cnt0_q == '0 && !blank_q));
endmodule

// File: rtl/ecc_rpt_pack.sv
module ecc_rpt_pack
    import ecc_rpt_pkg::*;
(
    input  logic                ok0,
    input  logic [CNT_W-1:0]    cnt0,
    input  logic                okn,
    input  logic [CNT_W-1:0]    cntn,
    input  logic                blank,
    output logic [REPORT_W-1:0] report,
    output logic [CNT_W-1:0]    bitflips,
    output logic                fail
);
    logic [CNT_W-1:0] worst;
    logic             all_ok;

    always_comb begin
        report                        = '0;
        report[CNT0_LSB +: CNT_W]     = cnt0;
        report[OK0_BIT]               = ok0;
        report[CNTN_LSB +: CNT_W]     = cntn;
        report[OKN_BIT]               = okn;
        report[EMPTY_BIT]             = blank;

        worst  = (cnt0 > cntn) ? cnt0 : cntn;
        all_ok = ok0 && okn;

        if (blank) begin
            bitflips = '0;
            fail     = 1'b0;
        end else if (all_ok) begin
            bitflips = worst;
            fail     = 1'b0;
        end else begin
            bitflips = '0;
            fail     = 1'b1;
        end
    end
endmodule

// File: rtl/ecc_page_report.sv
module ecc_page_report
    import ecc_rpt_pkg::*;
#(
    parameter int NUM_PKTS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                page_start,
    input  logic                pkt_valid,
    input  logic                pkt_ok,
    input  logic [CNT_W-1:0]    pkt_errs,
    input  logic                page_blank,
    output logic [REPORT_W-1:0] report_word,
    output logic                page_done,
    output logic [CNT_W-1:0]    page_bitflips,
    output logic                page_fail
);
    logic             take_first, take_rest, take_last;
    logic             ok0, okn, blank;
    logic [CNT_W-1:0] cnt0, cntn;

    ecc_rpt_seq #(.NUM_PKTS(NUM_PKTS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .page_start (page_start),
        .pkt_valid  (pkt_valid),
        .take_first (take_first),
        .take_rest  (take_rest),
        .take_last  (take_last),
        .page_done  (page_done)
    );

    ecc_rpt_fold u_fold (
        .clk        (clk),
        .rst_n      (rst_n),
        .page_start (page_start),
        .take_first (take_first),
        .take_rest  (take_rest),
        .take_last  (take_last),
        .pkt_ok     (pkt_ok),
        .pkt_errs   (pkt_errs),
        .page_blank (page_blank),
        .ok0_q      (ok0),
        .cnt0_q     (cnt0),
        .okn_q      (okn),
        .cntn_q     (cntn),
        .blank_q    (blank)
    );

    ecc_rpt_pack u_pack (
        .ok0      (ok0),
        .cnt0     (cnt0),
        .okn      (okn),
        .cntn     (cntn),
        .blank    (blank),
        .report   (report_word),
        .bitflips (page_bitflips),
        .fail     (page_fail)
    );

    // R5
    fail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        page_fail |-> (page_bitflips == '0));

    // R6
    blank_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        report_word[EMPTY_BIT] |-> (!page_fail && page_bitflips == '0));

    // R4
    done_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (page_done && !page_start) |=> $stable(report_word));
endmodule

// File: tb/ecc_page_report_test.sv
`timescale 1ns/1ps
module ecc_page_report_test;
    localparam int NP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        page_start = 1'b0;
    logic        pkt_valid = 1'b0;
    logic        pkt_ok = 1'b0;
    logic [5:0]  pkt_errs = '0;
    logic        page_blank = 1'b0;
    logic [31:0] report_word;
    logic        page_done;
    logic [5:0]  page_bitflips;
    logic        page_fail;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ecc_page_report #(.NUM_PKTS(NP)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .page_start    (page_start),
        .pkt_valid     (pkt_valid),
        .pkt_ok        (pkt_ok),
        .pkt_errs      (pkt_errs),
        .page_blank    (page_blank),
        .report_word   (report_word),
        .page_done     (page_done),
        .page_bitflips (page_bitflips),
        .page_fail     (page_fail)
    );

    // Behavioural reference model: 0 idle, 1 awaiting first, 2 awaiting rest, 3 done
    int m_phase = 0;
    int m_idx = 0;
    bit m_ok0 = 1'b1;
    int m_c0 = 0;
    bit m_okn = 1'b1;
    int m_cn = 0;
    bit m_emp = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_idx = 0; m_ok0 = 1; m_c0 = 0; m_okn = 1; m_cn = 0; m_emp = 0;
        end else if (page_start) begin
            m_phase = 1; m_idx = 0; m_ok0 = 1; m_c0 = 0; m_okn = 1; m_cn = 0; m_emp = 0;
        end else if (m_phase == 1) begin
            if (pkt_valid) begin
                m_ok0 = pkt_ok; m_c0 = int'(pkt_errs); m_idx = 1;
                if (NP == 1) begin m_emp = page_blank; m_phase = 3; end
                else m_phase = 2;
            end
        end else if (m_phase == 2) begin
            if (pkt_valid) begin
                m_okn = m_okn & pkt_ok;
                if (int'(pkt_errs) > m_cn) m_cn = int'(pkt_errs);
                if (m_idx == NP - 1) begin m_emp = page_blank; m_phase = 3; end
                else m_idx = m_idx + 1;
            end
        end else if (m_phase == 3) begin
            m_phase = 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_report();
        logic [31:0] r;
        r = '0;
        r[5:0]  = m_c0[5:0];
        r[7]    = m_ok0;
        r[13:8] = m_cn[5:0];
        r[15]   = m_okn;
        r[16]   = m_emp;
        return r;
    endfunction

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [31:0] er;
            logic [5:0]  eb;
            logic        ef;
            er = model_report();
            if (m_emp) begin eb = 0; ef = 0; end
            else if (m_ok0 && m_okn) begin eb = (m_c0 > m_cn) ? m_c0[5:0] : m_cn[5:0]; ef = 0; end
            else begin eb = 0; ef = 1; end
            chk(report_word[7:0] == er[7:0], "R1 packet0 byte", report_word, er);
            chk(report_word[15:8] == er[15:8], "R2 merged byte", report_word, er);
            chk(report_word[16] == er[16], "R6 empty bit", report_word, er);
            chk(report_word[31:17] == 15'd0, "R7 spare bits", report_word, er);
            chk(page_done == (m_phase == 3), "R4 done pulse", 32'(page_done), 32'(m_phase == 3));
            chk(page_bitflips == eb, "R5 bitflips", 32'(page_bitflips), 32'(eb));
            chk(page_fail == ef, "R5 fail", 32'(page_fail), 32'(ef));
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            page_start = 0; pkt_valid = 0; pkt_ok = 0; pkt_errs = 0; page_blank = 0;
        end
    endtask

    task automatic start();
        @(negedge clk);
        page_start = 1; pkt_valid = 0; pkt_ok = 0; pkt_errs = 0; page_blank = 0;
    endtask

    task automatic start_pkt(input bit ok, input int c);
        @(negedge clk);
        page_start = 1; pkt_valid = 1; pkt_ok = ok; pkt_errs = c[5:0]; page_blank = 0;
    endtask

    task automatic pkt(input bit ok, input int c, input bit blk);
        @(negedge clk);
        page_start = 0; pkt_valid = 1; pkt_ok = ok; pkt_errs = c[5:0]; page_blank = blk;
    endtask

    task automatic check_result(input string tag, input logic [31:0] rep, input int bf, input bit fl);
        chk(page_done == 1'b1, {tag, " R4 done"}, 32'(page_done), 32'd1);
        chk(report_word == rep, {tag, " R1/R2 report"}, report_word, rep);
        chk(page_bitflips == bf[5:0], {tag, " R5 bitflips"}, 32'(page_bitflips), 32'(bf));
        chk(page_fail == fl, {tag, " R5 fail"}, 32'(page_fail), 32'(fl));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R9 reset state
        chk(report_word == 32'h0000_8080, "R9 reset report", report_word, 32'h0000_8080);
        chk(!page_done && !page_fail && page_bitflips == 0, "R9 reset flags",
            {25'd0, page_done, page_fail, page_bitflips[4:0]}, 32'd0);

        // Page A: all ok, worst in merged packets, gap mid-page
        start();
        pkt(1, 3, 0); pkt(1, 5, 0); idle(1); pkt(1, 2, 0); pkt(1, 7, 0);
        idle(1);
        check_result("pageA", 32'h0000_8783, 7, 0);
        idle(1);
        chk(!page_done, "R4 done one cycle", 32'(page_done), 32'd0);
        chk(report_word == 32'h0000_8783, "R4 report stable", report_word, 32'h0000_8783);

        // R8: stray packets while idle
        pkt(0, 50, 1); pkt(0, 50, 1); pkt(1, 40, 0);
        idle(1);
        chk(report_word == 32'h0000_8783 && !page_done, "R8 idle ignore", report_word, 32'h0000_8783);

        // Page B: a merged packet fails (R2 sticky AND, R5 fail)
        start();
        pkt(1, 9, 0); pkt(0, 1, 0); pkt(1, 4, 0); pkt(1, 0, 0);
        idle(1);
        check_result("pageB", 32'h0000_0489, 0, 1);

        // Page C: packet 0 fails
        start();
        pkt(0, 63, 0); pkt(1, 1, 0); pkt(1, 1, 0); pkt(1, 1, 0);
        idle(1);
        check_result("pageC", 32'h0000_813f, 0, 1);

        // Page D: empty with last packet (R6)
        start();
        pkt(0, 10, 0); pkt(0, 10, 0); pkt(0, 10, 0); pkt(0, 10, 1);
        idle(1);
        check_result("pageD R6", 32'h0001_0a0a, 0, 0);

        // Page E: empty flag on a non-last packet is not sampled (R6)
        start();
        pkt(1, 2, 1); pkt(1, 3, 1); pkt(1, 1, 0); pkt(1, 0, 0);
        idle(1);
        check_result("pageE R6", 32'h0000_8382, 3, 0);

        // Page F: full-scale counts in merged packets
        start();
        pkt(1, 0, 0); pkt(1, 63, 0); pkt(1, 62, 0); pkt(1, 1, 0);
        idle(1);
        check_result("pageF", 32'h0000_bf80, 63, 0);

        // R3: restart mid-page, start colliding with a valid packet
        start();
        pkt(0, 9, 0); pkt(0, 20, 0);
        start_pkt(0, 40);
        pkt(1, 1, 0);
        chk(report_word == 32'h0000_8080, "R3 restart clears", report_word, 32'h0000_8080);
        pkt(1, 2, 0); pkt(1, 3, 0); pkt(1, 4, 0);
        idle(1);
        check_result("R3 restart page", 32'h0000_8481, 4, 0);

        // Start directly out of the done cycle, back-to-back packets
        start();
        pkt(1, 5, 0); pkt(1, 6, 0); pkt(1, 6, 0); pkt(1, 2, 0);
        start();
        idle(1);
        chk(report_word == 32'h0000_8080 && !page_done, "R3 start after done", report_word, 32'h0000_8080);
        idle(2);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule